// File: doc/BRIEF.md
# Direct-Mapped Cache Line Store and Hit Datapath

This block is the storage and lookup half of a small direct-mapped cache placed between a processor and a slower external memory. It keeps sixteen lines, each holding a 10-bit tag and four 16-bit words, alongside a per-line valid bit. On every cycle it decodes the processor address into tag, line index and word offset. It reports whether that address misses, and it returns the selected word to the processor.

A separate controller sequences reads, line fills and writes. It does so by presenting a 4-bit state code (values 0 to 8) and a 2-bit fill counter. Four block registers stage one line between the array and the outside world. Each cycle they reload from the array entry at the current index. In a fill state, one of them captures an incoming memory word instead. In a merge state, one of them captures a processor write word instead. The whole line, tagged with the current address tag, is written back to the array only in the commit state, or in the write-check state when the access hits.

All pins are plain control, status and data levels driven by the controller's schedule. There is no valid/ready handshake at this block's edge: the controller owns pacing, and the block never applies back-pressure. Data is sampled on every rising clock edge according to the state code.

Top module: `cache_datapath`

## Requirements
- R1: The 16-bit address is decoded as tag = addr[15:6], line index = addr[5:2] and word offset = addr[1:0]; the index picks the array entry and valid bit, the offset picks the word.
- R2: `miss` is 1 when the valid bit of the indexed line is 0, or when it is 1 and the stored tag of that line differs from addr[15:6]; otherwise `miss` is 0.
- R3: The indexed array entry is written at a clock edge only when state is 3, or when state is 5 and `miss` is 0; the written value is the address tag together with the four block registers (register k in word slot k). No other entry changes, and in all other states no entry changes.
- R4: On every clock edge each block register loads word k of the indexed array entry, except for the single register overridden per R5 or R6.
- R5: When state is 4, block register addr[1:0] loads `wdata` instead of the array word.
- R6: When state is 2, block register `fill_cnt` loads `mem_rdata` instead of the array word.
- R7: While `rst_n` is low, all valid bits, all array entries and all block registers clear to 0, so every address misses and `rdata` reads 0 after reset.
- R8: At a clock edge with state 8, the valid bit of the indexed line becomes 1; valid bits change at no other time outside reset.
- R9: `rdata` equals block register addr[1:0], combinationally from the current offset.
- R10: `complete` is 1 when state is 8, or when state is 0 with `acc` = 1, `rd` = 1 and `miss` = 0; otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Processor address |
| wdata | input | 16 | Processor write word |
| acc | input | 1 | Processor access strobe |
| rd | input | 1 | Processor read request (1 = read) |
| state | input | 4 | Controller state code, 0 to 8 |
| fill_cnt | input | 2 | Controller word counter for line fills |
| mem_rdata | input | 16 | Low 16 bits of the external memory bus |
| miss | output | 1 | Lookup result for the current address |
| rdata | output | 16 | Word returned to the processor |
| complete | output | 1 | Access completion flag |

## Verification
The embedded assertions watch the cycle-level rules. They check that the array changes only under the write enable and then holds the tag plus staged words. They check that valid bits only ever rise, and only in the done state. They check that an unset valid bit always forces a miss, and that un-overridden block registers track the array output. Sequences only become visible over the bench's scenarios: a full four-word fill that later reads back as hits, a write hit merging one word, tag conflicts evicting a line, and long random runs of state codes checked against a reference model.

// File: rtl/cache_dp_pkg.sv
`timescale 1ns/1ps
package cache_dp_pkg;
  localparam int STATE_W = 4;
  localparam logic [STATE_W-1:0] ST_IDLE   = 4'd0;
  localparam logic [STATE_W-1:0] ST_REQ    = 4'd1;
  localparam logic [STATE_W-1:0] ST_FILL   = 4'd2;
  localparam logic [STATE_W-1:0] ST_COMMIT = 4'd3;
  localparam logic [STATE_W-1:0] ST_MERGE  = 4'd4;
  localparam logic [STATE_W-1:0] ST_WCHK   = 4'd5;
  localparam logic [STATE_W-1:0] ST_WAIT1  = 4'd6;
  localparam logic [STATE_W-1:0] ST_WAIT2  = 4'd7;
  localparam logic [STATE_W-1:0] ST_DONE   = 4'd8;
endpackage

// File: rtl/cache_valid_bits.sv
`timescale 1ns/1ps
module cache_valid_bits #(
  parameter int LINES = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             set_en,
  output logic             vld
);
  logic [LINES-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (!rst_n) bits_q <= '0;
    else if (set_en) bits_q[idx] <= 1'b1;
  end

  assign vld = bits_q[idx];

  // R8: a set request marks the line valid
  p_valid_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> bits_q[$past(idx)]);
  // R8: without a set request nothing changes
  p_valid_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !set_en |=> bits_q == $past(bits_q));
endmodule

// File: rtl/cache_line_store.sv
`timescale 1ns/1ps
module cache_line_store #(
  parameter int LINES   = 16,
  parameter int ENTRY_W = 74,
  localparam int IDX_W  = $clog2(LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   idx,
  input  logic               we,
  input  logic [ENTRY_W-1:0] wr_entry,
  output logic [ENTRY_W-1:0] rd_entry
);
  logic [ENTRY_W-1:0] mem_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[idx] <= wr_entry;
    end
  end

  assign rd_entry = mem_q[idx];

  // R3: a write stores exactly the presented entry
  p_write_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem_q[$past(idx)] == $past(wr_entry));
  // R3: with the enable low the indexed entry keeps its contents
  p_write_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> mem_q[$past(idx)] == $past(rd_entry));
endmodule

// File: rtl/cache_block_regs.sv
`timescale 1ns/1ps
module cache_block_regs
  import cache_dp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WORDS  = 4,
  localparam int OFF_W = $clog2(WORDS),
  localparam int LINE_W = DATA_W * WORDS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] state,
  input  logic [OFF_W-1:0]   off,
  input  logic [OFF_W-1:0]   cnt,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [DATA_W-1:0]  mdata,
  input  logic [LINE_W-1:0]  arr_line,
  output logic [LINE_W-1:0]  blk_line
);
  logic [WORDS-1:0] take_cpu;
  logic [WORDS-1:0] take_mem;

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] word_d;

    assign take_cpu[k] = (state == ST_MERGE) && (off == OFF_W'(k));
    assign take_mem[k] = (state == ST_FILL) && (cnt == OFF_W'(k));

    always_comb begin
      word_d = arr_line[k*DATA_W +: DATA_W];
      if (take_cpu[k]) word_d = wdata;
      else if (take_mem[k]) word_d = mdata;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) word_q <= '0;
      else word_q <= word_d;
    end

    assign blk_line[k*DATA_W +: DATA_W] = word_q;

    // R4: a register not chosen for override follows the array word
    p_follow_array_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(take_cpu[k] || take_mem[k]) |=> word_q == $past(arr_line[k*DATA_W +: DATA_W]));
  end

  // R5, R6: at most one register is overridden per cycle
  p_one_override_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_cpu | take_mem));
endmodule

// File: rtl/cache_datapath.sv
`timescale 1ns/1ps
module cache_datapath
  import cache_dp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  localparam int IDX_W  = $clog2(LINES),
  localparam int OFF_W  = $clog2(WORDS),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int LINE_W = DATA_W * WORDS,
  localparam int ENTRY_W = TAG_W + LINE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               acc,
  input  logic               rd,
  input  logic [STATE_W-1:0] state,
  input  logic [OFF_W-1:0]   fill_cnt,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               miss,
  output logic [DATA_W-1:0]  rdata,
  output logic               complete
);
  logic [TAG_W-1:0]   a_tag;
  logic [IDX_W-1:0]   a_idx;
  logic [OFF_W-1:0]   a_off;
  logic [ENTRY_W-1:0] rd_entry;
  logic [ENTRY_W-1:0] wr_entry;
  logic [LINE_W-1:0]  blk_line;
  logic [TAG_W-1:0]   stored_tag;
  logic               vld;
  logic               arr_we;
  logic               read_hit;

  assign a_tag = addr[ADDR_W-1 -: TAG_W];
  assign a_idx = addr[OFF_W +: IDX_W];
  assign a_off = addr[OFF_W-1:0];

  assign stored_tag = rd_entry[ENTRY_W-1 -: TAG_W];
  assign miss       = !vld || (stored_tag != a_tag);
  assign arr_we     = (state == ST_COMMIT) || ((state == ST_WCHK) && !miss);
  assign wr_entry   = {a_tag, blk_line};

  cache_valid_bits #(.LINES(LINES)) u_valid (
    .clk(clk), .rst_n(rst_n), .idx(a_idx),
    .set_en(state == ST_DONE), .vld(vld)
  );

  cache_line_store #(.LINES(LINES), .ENTRY_W(ENTRY_W)) u_store (
    .clk(clk), .rst_n(rst_n), .idx(a_idx), .we(arr_we),
    .wr_entry(wr_entry), .rd_entry(rd_entry)
  );

  cache_block_regs #(.DATA_W(DATA_W), .WORDS(WORDS)) u_blk (
    .clk(clk), .rst_n(rst_n), .state(state), .off(a_off), .cnt(fill_cnt),
    .wdata(wdata), .mdata(mem_rdata), .arr_line(rd_entry[LINE_W-1:0]),
    .blk_line(blk_line)
  );

  assign rdata    = blk_line[a_off*DATA_W +: DATA_W];
  assign read_hit = (state == ST_IDLE) && acc && rd && !miss;
  assign complete = read_hit || (state == ST_DONE);

  // R2: an unset valid bit always reports a miss
  p_invalid_misses_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |-> miss);
  // R10: completion in the idle state implies a hit
  p_idle_done_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (complete && state == ST_IDLE) |-> !miss);
  // R3: a write hit in the check state leaves the line hitting afterwards
  p_whit_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WCHK && !miss) |=> (stored_tag == $past(a_tag)) || ($past(a_idx) != a_idx));
endmodule

// File: tb/sim_cache_datapath.sv
`timescale 1ns/1ps
module sim_cache_datapath;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        acc = 1'b0;
  logic        rd = 1'b0;
  logic [3:0]  state = '0;
  logic [1:0]  fill_cnt = '0;
  logic [15:0] mem_rdata = '0;
  logic        miss;
  logic [15:0] rdata;
  logic        complete;

  int n_vec = 0;
  int n_bad = 0;

  // reference model
  logic [9:0]  m_tag [16];
  logic [15:0] m_dat [16][4];
  logic        m_vld [16];
  logic [15:0] m_blk [4];

  cache_datapath u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .acc(acc), .rd(rd),
    .state(state), .fill_cnt(fill_cnt), .mem_rdata(mem_rdata),
    .miss(miss), .rdata(rdata), .complete(complete)
  );

  always #10 clk = ~clk;

  function automatic logic f_miss(logic [15:0] a);
    return !m_vld[a[5:2]] || (m_tag[a[5:2]] != a[15:6]);   // R1, R2
  endfunction

  function automatic logic f_done(logic [3:0] s, logic a_c, logic r, logic [15:0] a);
    return (s == 4'd8) || (s == 4'd0 && a_c && r && !f_miss(a));   // R10
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin
      m_tag[i] = '0; m_vld[i] = 1'b0;
      for (int k = 0; k < 4; k++) m_dat[i][k] = '0;
    end
    for (int k = 0; k < 4; k++) m_blk[k] = '0;
  endtask

  task automatic model_edge();
    logic [3:0] ix;
    logic [15:0] nb [4];
    ix = addr[5:2];
    for (int k = 0; k < 4; k++) nb[k] = m_dat[ix][k];               // R4
    if (state == 4'd4) nb[addr[1:0]] = wdata;                       // R5
    else if (state == 4'd2) nb[fill_cnt] = mem_rdata;               // R6
    if (state == 4'd3 || (state == 4'd5 && !f_miss(addr))) begin   // R3
      m_tag[ix] = addr[15:6];
      for (int k = 0; k < 4; k++) m_dat[ix][k] = m_blk[k];
    end
    if (state == 4'd8) m_vld[ix] = 1'b1;                            // R8
    for (int k = 0; k < 4; k++) m_blk[k] = nb[k];
  endtask

  task automatic check(string req);
    logic em, ec;
    logic [15:0] ed;
    em = f_miss(addr);
    ec = f_done(state, acc, rd, addr);
    ed = m_blk[addr[1:0]];                                          // R9
    n_vec++;
    if (miss !== em || complete !== ec || rdata !== ed) begin
      n_bad++;
      $display("FAIL %s st=%0d a=%h: miss %b/%b complete %b/%b rdata %h/%h (act/exp)",
               req, state, addr, miss, em, complete, ec, rdata, ed);
    end
  endtask

  task automatic step(string req, logic [3:0] s, logic [15:0] a, logic [15:0] wd,
                      logic [1:0] c, logic [15:0] md, logic a_c, logic r);
    @(negedge clk);
    state = s; addr = a; wdata = wd; fill_cnt = c; mem_rdata = md; acc = a_c; rd = r;
    #2;
    check(req);
    @(posedge clk);
    model_edge();
  endtask

  task automatic fill_line(logic [15:0] a, logic [15:0] base);
    step("R1", 4'd0, a, 16'h0, 2'd0, 16'h0, 1'b1, 1'b1);
    step("R2", 4'd1, a, 16'h0, 2'd0, 16'h0, 1'b1, 1'b1);
    for (int w = 0; w < 4; w++) begin
      step("R6", 4'd2, a, 16'h0, 2'(w), base + 16'(w), 1'b1, 1'b1);
      step("R3", 4'd3, a, 16'h0, 2'(w), 16'hdead, 1'b1, 1'b1);
    end
    step("R8", 4'd8, a, 16'h0, 2'd0, 16'h0, 1'b1, 1'b1);
  endtask

  initial begin
    #3_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not end (act hung, exp finished)");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R7: after reset every address misses and rdata is zero
    step("R7", 4'd0, 16'h0000, 16'h0, 2'd0, 16'h0, 1'b1, 1'b1);
    step("R7", 4'd0, 16'hffff, 16'h0, 2'd0, 16'h0, 1'b1, 1'b1);
    step("R7", 4'd6, 16'h1234, 16'h0, 2'd0, 16'h0, 1'b1, 1'b0);

    // Read miss fill, then read hits on every offset (R6, R3, R8, R9, R10)
    fill_line(16'h4a58, 16'h1000);
    for (int w = 0; w < 4; w++) step("R9", 4'd0, 16'h4a58 | 16'(w), 16'h0, 2'd0, 16'h0, 1'b1, 1'b1);
    // R10: no completion without strobe or for a write request in state 0
    step("R10", 4'd0, 16'h4a59, 16'h0, 2'd0, 16'h0, 1'b0, 1'b1);
    step("R10", 4'd0, 16'h4a59, 16'h0, 2'd0, 16'h0, 1'b1, 1'b0);

    // Write hit: merge word 2, commit in state 5 (R5, R3)
    step("R5", 4'd4, 16'h4a5a, 16'hbeef, 2'd0, 16'h0, 1'b1, 1'b0);
    step("R3", 4'd5, 16'h4a5a, 16'hbeef, 2'd0, 16'h0, 1'b1, 1'b0);
    step("R8", 4'd8, 16'h4a5a, 16'h0, 2'd0, 16'h0, 1'b1, 1'b0);
    for (int w = 0; w < 4; w++) step("R9", 4'd0, 16'h4a58 | 16'(w), 16'h0, 2'd0, 16'h0, 1'b1, 1'b1);

    // Tag conflict on the same index misses (R2); write miss in state 5 does not write (R3)
    step("R2", 4'd0, 16'h8a58, 16'h0, 2'd0, 16'h0, 1'b1, 1'b1);
    step("R3", 4'd4, 16'h8a58, 16'h7777, 2'd0, 16'h0, 1'b1, 1'b0);
    step("R3", 4'd5, 16'h8a58, 16'h7777, 2'd0, 16'h0, 1'b1, 1'b0);
    step("R3", 4'd0, 16'h4a58, 16'h0, 2'd0, 16'h0, 1'b1, 1'b1);
    // Eviction by fill of conflicting tag
    fill_line(16'h8a5b, 16'h2000);
    step("R2", 4'd0, 16'h4a58, 16'h0, 2'd0, 16'h0, 1'b1, 1'b1);
    step("R9", 4'd0, 16'h8a5b, 16'h0, 2'd0, 16'h0, 1'b1, 1'b1);

    // Constrained random mix over a small address pool (R1..R10)
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] a;
      a = {($urandom % 3 == 0) ? 10'h155 : 10'h0aa, 4'($urandom % 4), 2'($urandom)};
      step("R4", 4'($urandom % 9), a, 16'($urandom), 2'($urandom), 16'($urandom),
           1'($urandom), 1'($urandom));
    end

    // Reset mid-run clears state again (R7)
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); model_reset();
    @(negedge clk); rst_n = 1'b1;
    step("R7", 4'd0, 16'h4a58, 16'h0, 2'd0, 16'h0, 1'b1, 1'b1);
    step("R7", 4'd0, 16'h8a5b, 16'h0, 2'd0, 16'h0, 1'b1, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule